// File: doc/BRIEF.md
# Associative Memory Road Matcher

This block is a small content-addressable pattern bank used to find track roads. Each stored pattern holds one coarse super-strip value per detector layer. Every incoming hit carries a layer number and a super-strip value. All patterns compare each hit at once. A pattern records a flag for every layer on which it has seen a hit equal to its own stored value.

When the end-of-event marker is accepted, the block stops taking hits. It then streams out the addresses of all patterns whose count of flagged layers meets a programmable threshold, in ascending order, over a valid/ready handshake. When the last road has been sent, all layer flags clear and hit intake resumes for the next event.

Patterns are written one layer slot at a time through a simple write port. The threshold is held in a register that can be written at run time.

Top module: `road_matcher`

## Requirements
- R1: After reset `hit_ready` is 1, `road_valid` is 0, the threshold is 7, and all layer flags are clear.
- R2: An accepted hit (`hit_valid`=1, `hit_eoe`=0, `hit_ready`=1) sets the flag of layer `hit_layer` in every pattern whose stored value for that layer equals `hit_ss`. One hit can therefore count for several patterns.
- R3: A pattern is a road when its number of flagged layers is at least the threshold. With the default threshold, 7 or 8 flagged layers make a road and 6 do not.
- R4: Repeated hits on a layer that is already flagged add nothing. Six distinct layers, each hit twice, do not make a road at threshold 7.
- R5: Roads are sent as `road_id` (the pattern address) in strictly ascending address order, each exactly once per event.
- R6: While `road_valid` is 1 and `road_ready` is 0, `road_valid` stays 1 and `road_id` holds its value.
- R7: `hit_ready` is 0 from the cycle after the end-of-event beat is accepted until readout completes. Hits offered during that time are not taken and do not affect the roads.
- R8: After readout every layer flag is clear. A following event with no hits yields no roads.
- R9: Writing `thresh_we`=1 loads `thresh_val` into the threshold register. Threshold 8 needs all layers; threshold 1 needs any single layer.
- R10: With `load_en`=1, the value `load_ss` replaces the stored value of layer `load_layer` in pattern `load_addr`, and the other slots are unchanged.
- R11: For an event with no roads, `road_valid` stays 0 and `hit_ready` returns to 1 one cycle after the end-of-event beat is seen as accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_en | input | 1 | Write one pattern layer slot |
| load_addr | input | ID_W | Pattern address to write |
| load_layer | input | LAYER_W | Layer slot to write |
| load_ss | input | SS_WIDTH | Super-strip value to store |
| thresh_we | input | 1 | Write the match threshold |
| thresh_val | input | CNT_W | New threshold value |
| hit_valid | input | 1 | Hit or end-of-event beat offered |
| hit_ready | output | 1 | Block accepts a beat |
| hit_eoe | input | 1 | Beat is the end-of-event marker, not a hit |
| hit_layer | input | LAYER_W | Layer of the hit |
| hit_ss | input | SS_WIDTH | Super-strip value of the hit |
| road_valid | output | 1 | A road address is offered |
| road_ready | input | 1 | Consumer takes the road |
| road_id | output | ID_W | Address of the matched pattern |

## Verification
The bench drives several event shapes. It sends full and seven-layer hits against six-layer ones to find the threshold edge. It sends repeated hits on the same layers to show that flags do not count twice. It gives shared super-strip values to identical patterns to show that one hit reaches many patterns in parallel. It sends an empty event right after a busy one to confirm that the flags clear. A stalled readout, with a hit offered during the stall that would complete an extra pattern, separates correct back-pressure from hits leaking into the readout. Runs at thresholds 8 and 1, together with a reloaded layer slot, separate the threshold register and the write port from the fixed default behaviour.

// File: rtl/road_pkg.sv
package road_pkg;
   typedef enum logic {
      ST_COLLECT = 1'b0,
      ST_DRAIN   = 1'b1
   } rm_state_e;
endpackage

// File: rtl/road_cell.sv
module road_cell #(
   parameter int NUM_LAYERS = 8,
   parameter int SS_WIDTH   = 8,
   parameter int LAYER_W    = 3,
   parameter int CNT_W      = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [LAYER_W-1:0]  wr_layer,
   input  logic [SS_WIDTH-1:0] wr_ss,
   input  logic                hit_en,
   input  logic [LAYER_W-1:0]  hit_layer,
   input  logic [SS_WIDTH-1:0] hit_ss,
   input  logic                clear,
   input  logic [CNT_W-1:0]    thresh,
   output logic                matched
);
   logic [SS_WIDTH-1:0]   slot_q [NUM_LAYERS];
   logic [NUM_LAYERS-1:0] seen_q;
   logic [CNT_W-1:0]      seen_cnt;

   for (genvar l = 0; l < NUM_LAYERS; l++) begin : g_layer
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_q[l] <= '0;
         end else if (wr_en && (wr_layer == LAYER_W'(l))) begin
            slot_q[l] <= wr_ss;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            seen_q[l] <= 1'b0;
         end else if (clear) begin
            seen_q[l] <= 1'b0;
         end else if (hit_en && (hit_layer == LAYER_W'(l)) && (hit_ss == slot_q[l])) begin
            seen_q[l] <= 1'b1;
         end
      end
   end

   always_comb begin
      seen_cnt = '0;
      for (int i = 0; i < NUM_LAYERS; i++) begin
         seen_cnt = seen_cnt + CNT_W'(seen_q[i]);
      end
   end

   assign matched = (seen_cnt >= thresh);
endmodule

// File: rtl/road_scan.sv
module road_scan #(
   parameter int NUM_PATTERNS = 16,
   parameter int ID_W         = 4
) (
   input  logic [NUM_PATTERNS-1:0] cand,
   output logic                    any,
   output logic [ID_W-1:0]         idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = NUM_PATTERNS - 1; i >= 0; i--) begin
         if (cand[i]) begin
            any = 1'b1;
            idx = ID_W'(i);
         end
      end
   end
endmodule

// File: rtl/road_matcher.sv
module road_matcher #(
   parameter int NUM_PATTERNS = 16,
   parameter int NUM_LAYERS   = 8,
   parameter int SS_WIDTH     = 8,
   parameter int THRESH_INIT  = 7,
   localparam int ID_W        = $clog2(NUM_PATTERNS),
   localparam int LAYER_W     = $clog2(NUM_LAYERS),
   localparam int CNT_W       = $clog2(NUM_LAYERS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_en,
   input  logic [ID_W-1:0]     load_addr,
   input  logic [LAYER_W-1:0]  load_layer,
   input  logic [SS_WIDTH-1:0] load_ss,
   input  logic                thresh_we,
   input  logic [CNT_W-1:0]    thresh_val,
   input  logic                hit_valid,
   output logic                hit_ready,
   input  logic                hit_eoe,
   input  logic [LAYER_W-1:0]  hit_layer,
   input  logic [SS_WIDTH-1:0] hit_ss,
   output logic                road_valid,
   input  logic                road_ready,
   output logic [ID_W-1:0]     road_id
);
   import road_pkg::*;

   if (NUM_PATTERNS < 2) begin : g_bad_np
      $error("road_matcher: NUM_PATTERNS must be at least 2");
   end
   if (NUM_LAYERS < 2) begin : g_bad_nl
      $error("road_matcher: NUM_LAYERS must be at least 2");
   end
   if (SS_WIDTH < 1) begin : g_bad_ss
      $error("road_matcher: SS_WIDTH must be at least 1");
   end
   if ((THRESH_INIT < 1) || (THRESH_INIT > NUM_LAYERS)) begin : g_bad_th
      $error("road_matcher: THRESH_INIT out of range");
   end

   rm_state_e             state_q;
   logic [CNT_W-1:0]      thresh_q;
   logic [NUM_PATTERNS-1:0] matched;
   logic [NUM_PATTERNS-1:0] sent_q;
   logic [NUM_PATTERNS-1:0] cand;
   logic                  cand_any;
   logic [ID_W-1:0]       cand_idx;
   logic                  beat_acc;
   logic                  hit_acc;
   logic                  eoe_acc;
   logic                  drain_done;

   assign hit_ready  = (state_q == ST_COLLECT);
   assign beat_acc   = hit_valid && hit_ready;
   assign hit_acc    = beat_acc && !hit_eoe;
   assign eoe_acc    = beat_acc && hit_eoe;
   assign cand       = matched & ~sent_q;
   assign road_valid = (state_q == ST_DRAIN) && cand_any;
   assign road_id    = cand_idx;
   assign drain_done = (state_q == ST_DRAIN) && !cand_any;

   for (genvar p = 0; p < NUM_PATTERNS; p++) begin : g_cell
      road_cell #(
         .NUM_LAYERS (NUM_LAYERS),
         .SS_WIDTH   (SS_WIDTH),
         .LAYER_W    (LAYER_W),
         .CNT_W      (CNT_W)
      ) u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (load_en && (load_addr == ID_W'(p))),
         .wr_layer  (load_layer),
         .wr_ss     (load_ss),
         .hit_en    (hit_acc),
         .hit_layer (hit_layer),
         .hit_ss    (hit_ss),
         .clear     (drain_done),
         .thresh    (thresh_q),
         .matched   (matched[p])
      );
   end

   road_scan #(
      .NUM_PATTERNS (NUM_PATTERNS),
      .ID_W         (ID_W)
   ) u_scan (
      .cand (cand),
      .any  (cand_any),
      .idx  (cand_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thresh_q <= CNT_W'(THRESH_INIT);
      end else if (thresh_we) begin
         thresh_q <= thresh_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_COLLECT;
      end else if (eoe_acc) begin
         state_q <= ST_DRAIN;
      end else if (drain_done) begin
         state_q <= ST_COLLECT;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sent_q <= '0;
      end else if (drain_done) begin
         sent_q <= '0;
      end else if (road_valid && road_ready) begin
         sent_q[cand_idx] <= 1'b1;
      end
   end
endmodule

// File: rtl/road_matcher_chk.sv
module road_matcher_chk #(
   parameter int ID_W = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            hit_valid,
   input logic            hit_ready,
   input logic            hit_eoe,
   input logic            road_valid,
   input logic            road_ready,
   input logic [ID_W-1:0] road_id
);
   AST_ROAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      road_valid && !road_ready |=> road_valid && $stable(road_id)); // R6

   AST_NO_INTAKE_IN_READOUT: assert property (@(posedge clk) disable iff (!rst_n)
      road_valid |-> !hit_ready); // R7

   AST_EOE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      hit_valid && hit_eoe && hit_ready |=> !hit_ready); // R7

   AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
      road_valid && road_ready |=> !road_valid || (road_id > $past(road_id))); // R5

   AST_RESUME_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_ready && !road_valid |=> hit_ready); // R11
endmodule

bind road_matcher road_matcher_chk #(.ID_W(ID_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .hit_valid  (hit_valid),
   .hit_ready  (hit_ready),
   .hit_eoe    (hit_eoe),
   .road_valid (road_valid),
   .road_ready (road_ready),
   .road_id    (road_id)
);

// File: tb/tb_road_matcher.sv
module tb_road_matcher;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 16;
   localparam int NL = 8;
   localparam int SW = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load_en = 1'b0;
   logic [3:0] load_addr = '0;
   logic [2:0] load_layer = '0;
   logic [7:0] load_ss = '0;
   logic       thresh_we = 1'b0;
   logic [3:0] thresh_val = '0;
   logic       hit_valid = 1'b0;
   logic       hit_ready;
   logic       hit_eoe = 1'b0;
   logic [2:0] hit_layer = '0;
   logic [7:0] hit_ss = '0;
   logic       road_valid;
   logic       road_ready = 1'b0;
   logic [3:0] road_id;

   int n_checks = 0;
   int n_fail = 0;

   logic [7:0] pat [NP][NL];
   int         thr = 7;
   int         hl [64];
   logic [7:0] hs [64];
   int         nh = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   road_matcher dut (
      .clk(clk), .rst_n(rst_n),
      .load_en(load_en), .load_addr(load_addr), .load_layer(load_layer), .load_ss(load_ss),
      .thresh_we(thresh_we), .thresh_val(thresh_val),
      .hit_valid(hit_valid), .hit_ready(hit_ready), .hit_eoe(hit_eoe),
      .hit_layer(hit_layer), .hit_ss(hit_ss),
      .road_valid(road_valid), .road_ready(road_ready), .road_id(road_id)
   );

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic report();
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   endtask

   task automatic load(input int p, input int l, input logic [7:0] s);
      @(negedge clk);
      load_en = 1'b1; load_addr = 4'(p); load_layer = 3'(l); load_ss = s;
      @(negedge clk);
      load_en = 1'b0;
      pat[p][l] = s;
   endtask

   task automatic set_thresh(input int t);
      @(negedge clk);
      thresh_we = 1'b1; thresh_val = 4'(t);
      @(negedge clk);
      thresh_we = 1'b0;
      thr = t;
   endtask

   task automatic add_pat(input int p, input logic [7:0] mask, input int reps);
      for (int r = 0; r < reps; r++)
         for (int l = 0; l < NL; l++)
            if (mask[l]) begin
               hl[nh] = l; hs[nh] = pat[p][l]; nh++;
            end
   endtask

   // stall > 0: hold road_ready low and offer a hit (layer sl, value sv) meanwhile
   task automatic run_event(input string req, input int stall, input int sl, input logic [7:0] sv);
      logic [NL-1:0] fl [NP];
      int exp_ids [NP];
      int nexp = 0;
      int got [NP];
      int ng = 0;
      int cyc = 0;
      for (int p = 0; p < NP; p++) fl[p] = '0;
      for (int h = 0; h < nh; h++)
         for (int p = 0; p < NP; p++)
            if (pat[p][hl[h]] == hs[h]) fl[p][hl[h]] = 1'b1;
      for (int p = 0; p < NP; p++)
         if ($countones(fl[p]) >= thr) begin exp_ids[nexp] = p; nexp++; end
      for (int h = 0; h < nh; h++) begin
         @(negedge clk);
         hit_valid = 1'b1; hit_eoe = 1'b0; hit_layer = 3'(hl[h]); hit_ss = hs[h];
      end
      @(negedge clk);
      hit_valid = 1'b1; hit_eoe = 1'b1;
      road_ready = (stall == 0);
      @(negedge clk);
      hit_valid = 1'b0; hit_eoe = 1'b0;
      chk(hit_ready == 1'b0, "R7", {req, " hit_ready after eoe"}, int'(hit_ready), 0);
      for (int s = 0; s < stall; s++) begin
         chk(road_valid == 1'b1, "R6", {req, " valid held in stall"}, int'(road_valid), 1);
         chk(int'(road_id) == exp_ids[0], "R6", {req, " id held in stall"}, int'(road_id), exp_ids[0]);
         chk(hit_ready == 1'b0, "R7", {req, " hit_ready in stall"}, int'(hit_ready), 0);
         hit_valid = 1'b1; hit_layer = 3'(sl); hit_ss = sv;
         @(negedge clk);
      end
      hit_valid = 1'b0;
      road_ready = 1'b1;
      while (!hit_ready && cyc < 200) begin
         if (road_valid && ng < NP) begin got[ng] = int'(road_id); ng++; end
         @(negedge clk);
         cyc++;
      end
      road_ready = 1'b0;
      chk(ng == nexp, req, " road count", ng, nexp);
      for (int i = 0; i < nexp && i < ng; i++)
         chk(got[i] == exp_ids[i], req, " road id in order", got[i], exp_ids[i]);
      if (nexp == 0 && stall == 0)
         chk(cyc == 1, "R11", {req, " cycles to resume"}, cyc, 1);
      nh = 0;
   endtask

   task automatic t_reset();
      chk(hit_ready == 1'b1, "R1", "hit_ready after reset", int'(hit_ready), 1);
      chk(road_valid == 1'b0, "R1", "road_valid after reset", int'(road_valid), 0);
   endtask

   task automatic t_majority(); // R1 default threshold, R3, R5
      add_pat(2, 8'hFF, 1);
      add_pat(10, 8'h7F, 1);
      add_pat(12, 8'h3F, 1);
      run_event("R3", 0, 0, 8'h00);
   endtask

   task automatic t_repeats(); // R4, R11
      add_pat(4, 8'h3F, 2);
      run_event("R4", 0, 0, 8'h00);
   endtask

   task automatic t_shared(); // R2, R10
      for (int l = 0; l < NL; l++) begin
         load(5, l, pat[3][l]);
         load(9, l, pat[3][l]);
      end
      add_pat(3, 8'hFE, 1);
      run_event("R2", 0, 0, 8'h00);
   endtask

   task automatic t_stall(); // R6, R7, R5
      add_pat(1, 8'hFF, 1);
      add_pat(6, 8'hFF, 1);
      add_pat(11, 8'h3F, 1);
      run_event("R7", 4, 6, pat[11][6]);
   endtask

   task automatic t_clear(); // R8
      run_event("R8", 0, 0, 8'h00);
   endtask

   task automatic t_thresh(); // R9, R10
      set_thresh(8);
      add_pat(7, 8'h7F, 1);
      add_pat(8, 8'hFF, 1);
      run_event("R9", 0, 0, 8'h00);
      load(5, 0, 8'd200);
      add_pat(3, 8'hFF, 1);
      run_event("R10", 0, 0, 8'h00);
      set_thresh(1);
      add_pat(0, 8'h08, 1);
      run_event("R9", 0, 0, 8'h00);
      set_thresh(7);
   endtask

   initial begin
      repeat (1000 * CLK_PERIOD) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      for (int p = 0; p < NP; p++)
         for (int l = 0; l < NL; l++)
            pat[p][l] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      for (int p = 0; p < NP; p++)
         for (int l = 0; l < NL; l++)
            load(p, l, 8'(p * NL + l + 1));
      t_majority();
      t_repeats();
      t_shared();
      t_stall();
      t_clear();
      t_thresh();
      report();
   end
endmodule